// File: doc/BRIEF.md
# Sixteen-Lane Staged Window Classifier

This block decides, for a group of sixteen neighbouring candidate window positions, which of them survive a chain of accept/reject stages. Upstream logic computes rectangle-feature values and streams them in one feature per beat, carrying one signed value for each of the sixteen lanes. For every feature the block compares each lane's value with that feature's threshold. The result picks one of two signed vote values, and the block adds the chosen vote to that lane's running stage score. When the last feature of a stage has arrived, each score is compared with the stage threshold. Lanes that fall short are cleared from a shared survivor mask.

All lanes advance in lockstep. A stage's features are requested only while at least one lane is still alive. Once the survivor mask becomes empty, the group is abandoned at once, so no further beats are taken and the block reports an all-zero result. Per-stage feature counts, stage thresholds, per-feature thresholds and vote pairs are held in a writable table. Features are stored back to back: stage zero's features come first, then stage one's, and so on. The controller walks this table with a single running pointer.

The controller has five states. IDLE waits for `start`. SETUP loads the stage's feature count and clears the scores. ACCUM takes beats. DECIDE applies the stage threshold to the mask. FINISH pulses `done`. The transitions are: IDLE to SETUP on start; SETUP to ACCUM when the count is non-zero, or to DECIDE when it is zero; ACCUM to DECIDE on the beat that completes the stage; DECIDE to FINISH when the mask empties or the final stage has been judged, otherwise DECIDE to SETUP for the next stage; FINISH to IDLE unconditionally.

Top module: `cascade_classifier`

## Requirements
- R1: While reset is held and right after it is released, `done` and `resp_ready` are low and `face_mask` is zero.
- R2: For each beat and lane, a lane value greater than or equal to the feature threshold (both signed) adds the feature's high vote to that lane's score; a smaller value adds the low vote.
- R3: At the end of a stage a lane stays alive only if it was alive before and its signed score is greater than or equal to the signed stage threshold; equality passes.
- R4: Stage s consumes exactly its table count of beats, and its features are table entries starting at the sum of the counts of stages 0 to s-1.
- R5: When the survivor mask becomes all zero after some stage, `done` rises with `face_mask` zero and no further beats are accepted for that group.
- R6: When the last stage (index NSTAGES-1) is judged with at least one lane alive, `done` rises with `face_mask` equal to the surviving lanes (bit i is lane i).
- R7: `resp_ready` is high only while a stage is gathering beats; cycles with `resp_valid` low leave the result unchanged and keep `resp_ready` high.
- R8: A stage whose count is zero takes no beats and judges every live lane on a score of zero.
- R9: `start` is ignored while a group is being evaluated.
- R10: `done` is a one-cycle pulse, and `face_mask` is zero whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_we | input | 1 | Write strobe for a stage entry |
| stg_addr | input | SA_W | Stage index to write |
| stg_cnt | input | CNT_W | Number of features in that stage |
| stg_thr | input | SCORE_W | Signed stage threshold |
| feat_we | input | 1 | Write strobe for a feature entry |
| feat_addr | input | FA_W | Feature entry index to write |
| feat_thr | input | FEAT_W | Signed feature threshold |
| feat_vlo | input | VOTE_W | Signed vote added when the value is below the threshold |
| feat_vhi | input | VOTE_W | Signed vote added when the value reaches the threshold |
| start | input | 1 | Begin evaluating a new group (honoured only when idle) |
| resp_valid | input | 1 | A feature beat is offered |
| resp_ready | output | 1 | The block takes the offered beat |
| resp_data | input | LANES*FEAT_W | Signed feature value per lane, lane i in bits [i*FEAT_W +: FEAT_W] |
| done | output | 1 | One-cycle pulse when the group's outcome is known |
| face_mask | output | LANES | Surviving lanes, valid with `done` |

## Verification
Two functions can resolve in the same DECIDE cycle: early rejection of the whole group and completion of the final stage. The bench builds a table in which all lanes survive the earlier stages and then gives the last stage an unreachable threshold. It judges the result by whether `done` arrives with an all-zero mask after exactly the full sum of beats. Stall patterns on `resp_valid` and a stray `start` inside a running group are applied to the same tables. The resulting masks and beat counts must match those of an unstalled run, with each expected value computed by a score-and-threshold model in the bench.

// File: rtl/cascade_pkg.sv
`timescale 1ns/1ps
package cascade_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCUM,
        ST_DECIDE,
        ST_FINISH
    } casc_state_t;
endpackage

// File: rtl/cascade_table.sv
`timescale 1ns/1ps
module cascade_table #(
    parameter int NSTAGES    = 24,
    parameter int FEAT_DEPTH = 1024,
    parameter int CNT_W      = 8,
    parameter int SCORE_W    = 16,
    parameter int FEAT_W     = 16,
    parameter int VOTE_W     = 8,
    parameter int SA_W       = 5,
    parameter int FA_W       = 10
) (
    input  logic                      clk,
    input  logic                      stg_we,
    input  logic [SA_W-1:0]           stg_waddr,
    input  logic [CNT_W-1:0]          stg_wcnt,
    input  logic signed [SCORE_W-1:0] stg_wthr,
    input  logic                      feat_we,
    input  logic [FA_W-1:0]           feat_waddr,
    input  logic signed [FEAT_W-1:0]  feat_wthr,
    input  logic signed [VOTE_W-1:0]  feat_wlo,
    input  logic signed [VOTE_W-1:0]  feat_whi,
    input  logic [SA_W-1:0]           stg_raddr,
    input  logic [FA_W-1:0]           feat_raddr,
    output logic [CNT_W-1:0]          stg_rcnt,
    output logic signed [SCORE_W-1:0] stg_rthr,
    output logic signed [FEAT_W-1:0]  feat_rthr,
    output logic signed [VOTE_W-1:0]  feat_rlo,
    output logic signed [VOTE_W-1:0]  feat_rhi
);
    logic [CNT_W-1:0]          cnt_mem  [NSTAGES];
    logic signed [SCORE_W-1:0] sthr_mem [NSTAGES];
    logic signed [FEAT_W-1:0]  fthr_mem [FEAT_DEPTH];
    logic signed [VOTE_W-1:0]  vlo_mem  [FEAT_DEPTH];
    logic signed [VOTE_W-1:0]  vhi_mem  [FEAT_DEPTH];

    always_ff @(posedge clk) begin
        if (stg_we) begin
            cnt_mem[stg_waddr]  <= stg_wcnt;
            sthr_mem[stg_waddr] <= stg_wthr;
        end
        if (feat_we) begin
            fthr_mem[feat_waddr] <= feat_wthr;
            vlo_mem[feat_waddr]  <= feat_wlo;
            vhi_mem[feat_waddr]  <= feat_whi;
        end
    end

    assign stg_rcnt  = cnt_mem[stg_raddr];
    assign stg_rthr  = sthr_mem[stg_raddr];
    assign feat_rthr = fthr_mem[feat_raddr];
    assign feat_rlo  = vlo_mem[feat_raddr];
    assign feat_rhi  = vhi_mem[feat_raddr];
endmodule

// File: rtl/cascade_lane.sv
`timescale 1ns/1ps
module cascade_lane #(
    parameter int FEAT_W  = 16,
    parameter int VOTE_W  = 8,
    parameter int SCORE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      acc,
    input  logic signed [FEAT_W-1:0]  resp,
    input  logic signed [FEAT_W-1:0]  thr,
    input  logic signed [VOTE_W-1:0]  vlo,
    input  logic signed [VOTE_W-1:0]  vhi,
    input  logic signed [SCORE_W-1:0] stage_thr,
    output logic                      pass
);
    localparam int EXT_W = SCORE_W - VOTE_W;

    logic signed [SCORE_W-1:0] score_q;
    logic signed [VOTE_W-1:0]  vote;
    logic signed [SCORE_W-1:0] vote_ext;

    assign vote     = (resp >= thr) ? vhi : vlo;
    assign vote_ext = {{EXT_W{vote[VOTE_W-1]}}, vote};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q <= '0;
        end else if (clear) begin
            score_q <= '0;
        end else if (acc) begin
            score_q <= score_q + vote_ext;
        end
    end

    assign pass = (score_q >= stage_thr);
endmodule

// File: rtl/cascade_ctrl.sv
`timescale 1ns/1ps
module cascade_ctrl
    import cascade_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int NSTAGES = 24,
    parameter int CNT_W   = 8,
    parameter int SA_W    = 5,
    parameter int FA_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resp_valid,
    input  logic [CNT_W-1:0] stg_cnt,
    input  logic [LANES-1:0] pass_vec,
    output logic             resp_ready,
    output logic             lane_clear,
    output logic             lane_acc,
    output logic [SA_W-1:0]  stage_idx,
    output logic [FA_W-1:0]  feat_idx,
    output logic             done,
    output logic [LANES-1:0] face_mask
);
    localparam logic [SA_W-1:0]  LAST_STAGE = SA_W'(NSTAGES - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT   = CNT_W'(1);

    casc_state_t      state_q, state_d;
    logic [SA_W-1:0]  stage_q;
    logic [FA_W-1:0]  ptr_q;
    logic [CNT_W-1:0] remain_q;
    logic [LANES-1:0] live_q;
    logic [LANES-1:0] live_cut;
    logic             fire;

    assign live_cut = live_q & pass_vec;
    assign fire     = (state_q == ST_ACCUM) && resp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = (stg_cnt == '0) ? ST_DECIDE : ST_ACCUM;
            ST_ACCUM:  if (fire && remain_q == ONE_LEFT) state_d = ST_DECIDE;
            ST_DECIDE: state_d = (live_cut == '0 || stage_q == LAST_STAGE)
                                 ? ST_FINISH : ST_SETUP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // stage, pointer, countdown and survivor mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= '0;
            ptr_q    <= '0;
            remain_q <= '0;
            live_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        stage_q <= '0;
                        ptr_q   <= '0;
                        live_q  <= '1;
                    end
                end
                ST_SETUP: remain_q <= stg_cnt;
                ST_ACCUM: begin
                    if (fire) begin
                        ptr_q    <= ptr_q + FA_W'(1);
                        remain_q <= remain_q - ONE_LEFT;
                    end
                end
                ST_DECIDE: begin
                    live_q <= live_cut;
                    if (live_cut != '0 && stage_q != LAST_STAGE) begin
                        stage_q <= stage_q + SA_W'(1);
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        resp_ready = (state_q == ST_ACCUM);
        lane_clear = (state_q == ST_SETUP);
        lane_acc   = fire;
        done       = (state_q == ST_FINISH);
        face_mask  = (state_q == ST_FINISH) ? live_q : '0;
    end

    assign stage_idx = stage_q;
    assign feat_idx  = ptr_q;
endmodule

// File: rtl/cascade_classifier.sv
`timescale 1ns/1ps
module cascade_classifier #(
    parameter int LANES      = 16,
    parameter int NSTAGES    = 24,
    parameter int FEAT_DEPTH = 1024,
    parameter int MAX_FEAT   = 255,
    parameter int FEAT_W     = 16,
    parameter int VOTE_W     = 8,
    parameter int CNT_W      = $clog2(MAX_FEAT + 1),
    parameter int SCORE_W    = VOTE_W + CNT_W + 1,
    parameter int SA_W       = $clog2(NSTAGES),
    parameter int FA_W       = $clog2(FEAT_DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stg_we,
    input  logic [SA_W-1:0]           stg_addr,
    input  logic [CNT_W-1:0]          stg_cnt,
    input  logic signed [SCORE_W-1:0] stg_thr,
    input  logic                      feat_we,
    input  logic [FA_W-1:0]           feat_addr,
    input  logic signed [FEAT_W-1:0]  feat_thr,
    input  logic signed [VOTE_W-1:0]  feat_vlo,
    input  logic signed [VOTE_W-1:0]  feat_vhi,
    input  logic                      start,
    input  logic                      resp_valid,
    output logic                      resp_ready,
    input  logic [LANES*FEAT_W-1:0]   resp_data,
    output logic                      done,
    output logic [LANES-1:0]          face_mask
);
    logic [CNT_W-1:0]          cur_cnt;
    logic signed [SCORE_W-1:0] cur_sthr;
    logic signed [FEAT_W-1:0]  cur_fthr;
    logic signed [VOTE_W-1:0]  cur_vlo;
    logic signed [VOTE_W-1:0]  cur_vhi;
    logic [SA_W-1:0]           stage_idx;
    logic [FA_W-1:0]           feat_idx;
    logic                      lane_clear;
    logic                      lane_acc;
    logic [LANES-1:0]          pass_vec;

    cascade_table #(
        .NSTAGES(NSTAGES), .FEAT_DEPTH(FEAT_DEPTH), .CNT_W(CNT_W),
        .SCORE_W(SCORE_W), .FEAT_W(FEAT_W), .VOTE_W(VOTE_W),
        .SA_W(SA_W), .FA_W(FA_W)
    ) u_table (
        .clk        (clk),
        .stg_we     (stg_we),
        .stg_waddr  (stg_addr),
        .stg_wcnt   (stg_cnt),
        .stg_wthr   (stg_thr),
        .feat_we    (feat_we),
        .feat_waddr (feat_addr),
        .feat_wthr  (feat_thr),
        .feat_wlo   (feat_vlo),
        .feat_whi   (feat_vhi),
        .stg_raddr  (stage_idx),
        .feat_raddr (feat_idx),
        .stg_rcnt   (cur_cnt),
        .stg_rthr   (cur_sthr),
        .feat_rthr  (cur_fthr),
        .feat_rlo   (cur_vlo),
        .feat_rhi   (cur_vhi)
    );

    cascade_ctrl #(
        .LANES(LANES), .NSTAGES(NSTAGES), .CNT_W(CNT_W),
        .SA_W(SA_W), .FA_W(FA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .resp_valid (resp_valid),
        .stg_cnt    (cur_cnt),
        .pass_vec   (pass_vec),
        .resp_ready (resp_ready),
        .lane_clear (lane_clear),
        .lane_acc   (lane_acc),
        .stage_idx  (stage_idx),
        .feat_idx   (feat_idx),
        .done       (done),
        .face_mask  (face_mask)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cascade_lane #(
            .FEAT_W(FEAT_W), .VOTE_W(VOTE_W), .SCORE_W(SCORE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (lane_clear),
            .acc       (lane_acc),
            .resp      (resp_data[g*FEAT_W +: FEAT_W]),
            .thr       (cur_fthr),
            .vlo       (cur_vlo),
            .vhi       (cur_vhi),
            .stage_thr (cur_sthr),
            .pass      (pass_vec[g])
        );
    end
endmodule

// File: rtl/cascade_classifier_chk.sv
`timescale 1ns/1ps
module cascade_classifier_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic             done,
    input logic [LANES-1:0] face_mask
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!done && !resp_ready);
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> face_mask == '0);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ready && !resp_valid) |=> resp_ready);

    // R5
    done_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !resp_ready);
endmodule

bind cascade_classifier cascade_classifier_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .done       (done),
    .face_mask  (face_mask)
);

// File: tb/cascade_classifier_test.sv
`timescale 1ns/1ps
module cascade_classifier_test;
    localparam int LANES = 16;
    localparam int NST   = 3;
    localparam int FD    = 32;
    localparam int MAXF  = 7;
    localparam int FW    = 8;
    localparam int VW    = 8;
    localparam int CW    = 3;
    localparam int SW    = VW + CW + 1;
    localparam int SAW   = 2;
    localparam int FAW   = 5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   stg_we = 1'b0;
    logic [SAW-1:0]         stg_addr = '0;
    logic [CW-1:0]          stg_cnt = '0;
    logic [SW-1:0]          stg_thr = '0;
    logic                   feat_we = 1'b0;
    logic [FAW-1:0]         feat_addr = '0;
    logic [FW-1:0]          feat_thr = '0;
    logic [VW-1:0]          feat_vlo = '0;
    logic [VW-1:0]          feat_vhi = '0;
    logic                   start = 1'b0;
    logic                   resp_valid = 1'b0;
    logic                   resp_ready;
    logic [LANES*FW-1:0]    resp_data = '0;
    logic                   done;
    logic [LANES-1:0]       face_mask;

    cascade_classifier #(
        .LANES(LANES), .NSTAGES(NST), .FEAT_DEPTH(FD), .MAX_FEAT(MAXF),
        .FEAT_W(FW), .VOTE_W(VW)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .stg_we(stg_we), .stg_addr(stg_addr), .stg_cnt(stg_cnt), .stg_thr(stg_thr),
        .feat_we(feat_we), .feat_addr(feat_addr), .feat_thr(feat_thr),
        .feat_vlo(feat_vlo), .feat_vhi(feat_vhi),
        .start(start), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_data(resp_data), .done(done), .face_mask(face_mask)
    );

    always #2 clk = ~clk;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;

    int st_cnt [NST];
    int st_thr [NST];
    int f_thr  [FD];
    int f_lo   [FD];
    int f_hi   [FD];
    int resp   [FD][LANES];
    int unsigned rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        int r;
        rng = rng * 32'd1103515245 + 32'd12345;
        r = int'((rng >> 8) % (hi - lo + 1));
        return lo + r;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic load_all();
        for (int s = 0; s < NST; s++) begin
            @(negedge clk);
            stg_we = 1'b1; stg_addr = SAW'(s);
            stg_cnt = CW'(st_cnt[s]); stg_thr = SW'(st_thr[s]);
        end
        @(negedge clk); stg_we = 1'b0;
        for (int f = 0; f < FD; f++) begin
            feat_we = 1'b1; feat_addr = FAW'(f);
            feat_thr = FW'(f_thr[f]); feat_vlo = VW'(f_lo[f]); feat_vhi = VW'(f_hi[f]);
            @(negedge clk);
        end
        feat_we = 1'b0;
    endtask

    task automatic model(output int exp_mask, output int exp_beats);
        int live = 16'hffff;
        int ptr  = 0;
        int sc [LANES];
        exp_beats = 0;
        for (int s = 0; s < NST; s++) begin
            for (int l = 0; l < LANES; l++) sc[l] = 0;
            for (int k = 0; k < st_cnt[s]; k++) begin
                for (int l = 0; l < LANES; l++)
                    sc[l] += (resp[ptr][l] >= f_thr[ptr]) ? f_hi[ptr] : f_lo[ptr];
                ptr++;
                exp_beats++;
            end
            for (int l = 0; l < LANES; l++)
                if (sc[l] < st_thr[s]) live &= ~(1 << l);
            if (live == 0) break;
        end
        exp_mask = live;
    endtask

    // mode 0: continuous beats, 1: stalls, 2: stalls plus a stray start
    task automatic run_group(input int mode, output int mask, output int beats);
        int n = 0;
        int c = 0;
        bit fire;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        mask = -1;
        forever begin
            if (done) begin
                mask = int'(face_mask);
                break;
            end
            if (c > 2000) break;
            resp_valid = (mode == 0) ? 1'b1 : ((c % 3) != 1);
            start = (mode == 2 && c == 1);
            for (int l = 0; l < LANES; l++)
                resp_data[l*FW +: FW] = (n < FD) ? FW'(resp[n][l]) : '0;
            fire = resp_valid && resp_ready;
            @(negedge clk);
            if (fire) n++;
            c++;
        end
        resp_valid = 1'b0;
        start = 1'b0;
        beats = n;
    endtask

    task automatic trial(input int mode, input string tag);
        int em, eb, am, ab;
        load_all();
        model(em, eb);
        run_group(mode, am, ab);
        chk(am == em, {tag, " R3 R5 R6 mask"}, am, em);
        chk(ab == eb, {tag, " R4 beats consumed"}, ab, eb);
        @(negedge clk);
        chk(!done && face_mask == '0, {tag, " R10 done pulse"}, int'(done), 0);
        @(negedge clk);
        chk(!resp_ready, {tag, " R9 R7 no restart"}, int'(resp_ready), 0);
    endtask

    task automatic fill_random();
        for (int s = 0; s < NST; s++) begin
            st_cnt[s] = rnd(0, MAXF);
            st_thr[s] = rnd(-20, 20);
        end
        for (int f = 0; f < FD; f++) begin
            f_thr[f] = rnd(-40, 40);
            f_lo[f]  = rnd(-9, 0);
            f_hi[f]  = rnd(0, 9);
            for (int l = 0; l < LANES; l++) resp[f][l] = rnd(-64, 63);
        end
    endtask

    initial begin
        int am, ab;
        repeat (3) @(negedge clk);
        chk(!done && !resp_ready && face_mask == '0, "R1 in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !resp_ready && face_mask == '0, "R1 after reset", int'(resp_ready), 0);
        resp_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(!resp_ready, "R7 idle ignores valid", int'(resp_ready), 0);
        resp_valid = 1'b0;

        // all lanes pass every stage
        fill_random();
        for (int s = 0; s < NST; s++) begin st_cnt[s] = 5; st_thr[s] = -1024; end
        trial(0, "all-pass R6");
        trial(1, "all-pass stalled R7");

        // stage zero rejects every lane
        st_thr[0] = 1023; st_cnt[0] = 2;
        trial(0, "early reject R5");

        // zero-count middle stage, threshold 0 then 1
        st_thr[0] = -1024; st_cnt[1] = 0; st_thr[1] = 0;
        trial(0, "empty stage pass R8");
        st_thr[1] = 1;
        trial(0, "empty stage reject R8");

        // threshold equality in vote and stage compare
        st_cnt[0] = 1; st_thr[0] = 1; st_cnt[1] = 2; st_thr[1] = -1024; st_thr[2] = -1024;
        f_thr[0] = 0; f_lo[0] = -1; f_hi[0] = 1;
        for (int l = 0; l < LANES; l++) resp[0][l] = l - 8;
        load_all();
        run_group(0, am, ab);
        chk(am == 16'hff00, "R2 R3 equality boundaries", am, 16'hff00);
        @(negedge clk);

        // last stage rejects everything: early exit and completion coincide
        st_cnt[0] = 3; st_cnt[1] = 4; st_cnt[2] = 6;
        st_thr[0] = -1024; st_thr[1] = -1024; st_thr[2] = 1023;
        trial(0, "final-stage reject R5 R6");
        trial(2, "final-stage reject with stray start R9");

        for (int t = 0; t < 45; t++) begin
            fill_random();
            trial(t % 3, "random R2 R3 R4");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule